// File: doc/BRIEF.md
# Gated Programmable Clock Post-Divider

This block derives a slower clock waveform from a fast source clock by integer division, with the ratio chosen by software through a single 16-bit control word. Everything runs on the source clock. The output `div_clk_o` is a registered-state waveform that repeats every N source cycles, where N is the active ratio. It can be used as a clock enable or fed to a clock gating cell.

A new ratio is held as pending and is adopted only when the current output period ends. Its adoption is signalled by flipping a read-only acknowledge bit. The output can follow a consumer demand input, which stops it at a period end once demand goes away, or it can be kept running. A sleep bit stops the divider at the next period end and holds it stopped. While the divider is asleep, any pending ratio waits until the divider wakes. A read-only run bit shows whether the output is currently active.

Top module: `clk_postdiv`

## Requirements
- R1: The ratio field is control word bits [4:0] and accepts values 1 to 31. After reset it holds 3. It reads back the last accepted value.
- R2: After reset, the control word reads 16'h0003 and `div_clk_o` is 0. All control bits are 0, and the run and acknowledge bits are 0.
- R3: While running with ratio N, each output period lasts N source cycles. The output is 1 for the first floor(N/2) cycles of each period and 0 for the rest. With N = 1 the output stays at 1.
- R4: A newly written ratio takes effect only after the last cycle of the current period. Until then the output keeps the old ratio.
- R5: The acknowledge bit (bit 9) flips in the first cycle that runs at a newly adopted ratio. It flips exactly once per adoption.
- R6: A write whose ratio field is 0 leaves the ratio unchanged. It causes no acknowledge flip and no change to the waveform. The other control bits in that write are still accepted.
- R7: When keep-running (bit 6) is 0, the output runs while `demand_i` is 1. Once demand is 0 it stops at the end of a period. A stopped divider restarts one cycle after it sees demand.
- R8: When keep-running is 1, the output runs whatever the level of `demand_i`.
- R9: The run bit (bit 8) is 1 exactly in the cycles the divider runs. The output is 0 whenever the run bit is 0.
- R10: Sleep (bit 7) set to 1 stops the output at the next period end and keeps it stopped with the counter at zero. A ratio written while asleep is adopted, with an acknowledge flip, only once sleep is cleared.
- R11: Bit 5 and bits 15:10 read 0 and ignore writes. The run and acknowledge bits cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control and status word |
| demand_i | input | 1 | Consumer request for the output |
| div_clk_o | output | 1 | Divided output waveform |

## Verification
The embedded assertions check several properties on every cycle. The active ratio is never zero and the counter stays below it. The output is low whenever the run bit is low. Any change of the active ratio comes with an acknowledge flip. Stopping happens only on the last cycle of a period. A sleeping divider stays stopped. A zero-ratio write leaves the stored ratio alone.

Other behaviour shows only in the bench's scenarios against its cycle-by-cycle model. These cover the exact high and low phase lengths for odd, even and unit ratios, the cycle in which a pending ratio lands, restart latency after demand returns, and the release of a ratio held during sleep.

// File: rtl/clk_postdiv_pkg.sv
package clk_postdiv_pkg;
  localparam int RATIO_W   = 5;
  localparam int REG_W     = 16;
  localparam int KEEP_BIT  = 6;
  localparam int SLEEP_BIT = 7;
  localparam int RUN_BIT   = 8;
  localparam int ACK_BIT   = 9;
  localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(3);

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef struct packed {
    logic   keep_on;
    logic   sleep;
    logic   pend_vld;
    ratio_t pend_ratio;
  } ctl_t;
endpackage

// File: rtl/postdiv_regs.sv
module postdiv_regs
  import clk_postdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             apply_i,
  output ctl_t             ctl_o,
  output ratio_t           ratio_rd_o
);

  ratio_t ratio_in;
  logic   wr_ok;
  logic   keep_q, sleep_q, pvld_q, pvld_d;
  ratio_t pend_q, rd_q;
  logic   unused_wr;

  assign unused_wr = ^{wr_data[REG_W-1:SLEEP_BIT+1], wr_data[KEEP_BIT-1:RATIO_W]};

  always_comb begin
    ratio_in = wr_data[RATIO_W-1:0];
    wr_ok    = wr_en && (ratio_in != '0);
    if (wr_ok)        pvld_d = 1'b1;
    else if (apply_i) pvld_d = 1'b0;
    else              pvld_d = pvld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q  <= 1'b0;
      sleep_q <= 1'b0;
    end else if (wr_en) begin
      keep_q  <= wr_data[KEEP_BIT];
      sleep_q <= wr_data[SLEEP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= RATIO_RST;
      rd_q   <= RATIO_RST;
    end else if (wr_ok) begin
      pend_q <= ratio_in;
      rd_q   <= ratio_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pvld_q <= 1'b0;
    else        pvld_q <= pvld_d;
  end

  assign ctl_o = '{keep_on: keep_q, sleep: sleep_q, pend_vld: pvld_q, pend_ratio: pend_q};
  assign ratio_rd_o = rd_q;

  // R6
  zero_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[RATIO_W-1:0] == '0) |=> ($stable(rd_q) && $stable(pend_q)));

endmodule

// File: rtl/postdiv_core.sv
module postdiv_core
  import clk_postdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t ctl_i,
  input  logic demand_i,
  output logic apply_o,
  output logic run_o,
  output logic ack_o,
  output logic div_clk_o
);

  ratio_t cnt_q, cnt_d, act_q, act_d, hi_len;
  logic   run_q, run_d, ack_q, ack_d;
  logic   last_cyc, bnd, apply, want;

  always_comb begin
    last_cyc = (cnt_q == act_q - 1'b1);
    bnd      = !run_q || last_cyc;
    want     = !ctl_i.sleep && (ctl_i.keep_on || demand_i);
    apply    = bnd && !ctl_i.sleep && ctl_i.pend_vld;
    cnt_d    = bnd ? '0 : ratio_t'(cnt_q + 1'b1);
    act_d    = apply ? ctl_i.pend_ratio : act_q;
    run_d    = bnd ? want : run_q;
    ack_d    = ack_q ^ apply;
    hi_len   = act_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      act_q <= RATIO_RST;
      ack_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      if (apply) begin
        act_q <= act_d;
        ack_q <= ack_d;
      end
    end
  end

  assign apply_o   = apply;
  assign run_o     = run_q;
  assign ack_o     = ack_q;
  assign div_clk_o = run_q && ((act_q == RATIO_W'(1)) || (cnt_q < hi_len));

  // R1
  ratio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q != '0);

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_q);

  // R5
  ack_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> (ack_q != $past(ack_q)));

  // R7
  stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(cnt_q) == $past(act_q) - 1'b1));

  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.sleep && !run_q) |=> !run_q);

endmodule

// File: rtl/clk_postdiv.sv
module clk_postdiv
  import clk_postdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             demand_i,
  output logic             div_clk_o
);

  ctl_t   ctl;
  ratio_t ratio_rd;
  logic   apply, run, ack;

  postdiv_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .apply_i    (apply),
    .ctl_o      (ctl),
    .ratio_rd_o (ratio_rd)
  );

  postdiv_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_i     (ctl),
    .demand_i  (demand_i),
    .apply_o   (apply),
    .run_o     (run),
    .ack_o     (ack),
    .div_clk_o (div_clk_o)
  );

  always_comb begin
    rd_data                = '0;
    rd_data[RATIO_W-1:0]   = ratio_rd;
    rd_data[KEEP_BIT]      = ctl.keep_on;
    rd_data[SLEEP_BIT]     = ctl.sleep;
    rd_data[RUN_BIT]       = run;
    rd_data[ACK_BIT]       = ack;
  end

  // R9
  gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[RUN_BIT] |-> !div_clk_o);

endmodule

// File: tb/tb_clk_postdiv.sv
module tb_clk_postdiv;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        demand_i;
  logic        div_clk_o;

  int n_chk = 0;
  int n_err = 0;

  clk_postdiv dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .demand_i(demand_i), .div_clk_o(div_clk_o)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference
  int m_cnt, m_ratio, m_wr, m_pr;
  bit m_run, m_ack, m_pv, m_keep, m_sleep;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ratio = 3; m_wr = 3; m_pr = 3;
      m_run = 0; m_ack = 0; m_pv = 0; m_keep = 0; m_sleep = 0;
    end else begin
      bit want;
      want = !m_sleep && (m_keep || demand_i);
      if (!m_run || m_cnt == m_ratio - 1) begin
        if (!m_sleep && m_pv) begin
          m_ratio = m_pr; m_pv = 0; m_ack = !m_ack;
        end
        m_cnt = 0;
        m_run = want;
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (wr_en) begin
        m_keep  = wr_data[6];
        m_sleep = wr_data[7];
        if (wr_data[4:0] != 0) begin
          m_wr = wr_data[4:0]; m_pr = wr_data[4:0]; m_pv = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, sampled away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_out;
      e_out = m_run && (m_ratio == 1 || m_cnt < m_ratio / 2);
      chk(div_clk_o == e_out, "R3 R4 waveform", div_clk_o, e_out);
      chk(rd_data[4:0] == m_wr[4:0], "R1 ratio readback", rd_data[4:0], m_wr);
      chk(rd_data[8] == m_run, "R9 run bit", rd_data[8], m_run);
      chk(rd_data[9] == m_ack, "R5 ack bit", rd_data[9], m_ack);
      chk(rd_data[7:6] == {m_sleep, m_keep}, "R11 control bits", rd_data[7:6], {m_sleep, m_keep});
      chk(rd_data[15:10] == 0 && rd_data[5] == 0, "R11 reserved zero", rd_data, 0);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(CLK_P * 50000);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit ack_s;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; demand_i = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R2
    chk(rd_data == 16'h0003, "R2 reset word", rd_data, 16'h0003);
    chk(div_clk_o == 1'b0, "R2 reset output", div_clk_o, 0);

    demand_i = 1'b1;
    cyc(20);
    wr(16'h0005);            // R4: mid-period change
    cyc(30);
    ack_s = rd_data[9];
    wr(16'h0000);            // R6: zero ratio ignored
    cyc(2);
    chk(rd_data[4:0] == 5, "R6 ratio kept", rd_data[4:0], 5);
    chk(rd_data[9] == ack_s, "R6 no ack flip", rd_data[9], ack_s);
    cyc(20);
    wr(16'h0004);
    cyc(20);
    wr(16'h0001);            // R3: unit ratio
    cyc(6);
    for (int i = 0; i < 4; i++) begin
      chk(div_clk_o == 1'b1, "R3 unit ratio high", div_clk_o, 1);
      cyc(1);
    end
    wr(16'h0006);
    cyc(10);
    demand_i = 1'b0;         // R7
    cyc(20);
    chk(rd_data[8] == 1'b0, "R7 gated without demand", rd_data[8], 0);
    demand_i = 1'b1;
    cyc(2);
    demand_i = 1'b0;
    cyc(20);
    wr(16'h0042);            // R8: keep running, ratio 2
    cyc(20);
    chk(rd_data[8] == 1'b1, "R8 forced running", rd_data[8], 1);
    ack_s = rd_data[9];
    wr(16'h00C7);            // R10: sleep with pending ratio 7
    cyc(20);
    chk(rd_data[8] == 1'b0, "R10 asleep", rd_data[8], 0);
    chk(rd_data[9] == ack_s, "R10 pending held", rd_data[9], ack_s);
    wr(16'h0040);            // wake, ratio field 0
    cyc(20);
    chk(rd_data[9] != ack_s, "R10 applied on wake", rd_data[9], !ack_s);
    chk(rd_data[8] == 1'b1, "R10 running again", rd_data[8], 1);
    wr(16'hFFFF);            // R11
    cyc(3);
    chk(rd_data[15:10] == 0 && rd_data[5] == 0, "R11 writes ignored", rd_data, 16'h03DF);
    wr(16'h0043);
    cyc(40);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule